// File: doc/BRIEF.md
# Multi-Pattern Link Test Word Generator and Checker

This block drives a 40-bit parallel test word toward a serial link channel and judges the words that come back. A two-bit select, shared by both halves, picks one of four patterns: a 7th-order pseudo-random sequence, a 15th-order pseudo-random sequence, an incrementing count, or a fixed alternating nibble word. The receive half follows only the two pseudo-random patterns. It locks onto the incoming sequence without any shared seed and raises a sync flag once locked. While locked, it adds every mismatching bit to a saturating error total.

A test operator can corrupt exactly one outgoing word by pulsing the inject input. A good link then shows an error total of one, which proves that the checker is alive. Changing the select restarts the generator from a fixed nonzero seed, clears the error total and forces the checker to lock again. The outgoing words leave through a valid/ready stream. `tx_valid` does not depend on `tx_ready`. While `tx_ready` is low, the presented word and the sequence position hold. `tx_valid` drops only in the single cycle in which a new select value is being taken. The receive side applies no back-pressure: `rx_ready` is high whenever the block is out of reset, and a word is consumed in every cycle in which `rx_valid` is high.

Top module: `ptg_top`

## Requirements
- R1: While `rst_n` is low: `tx_valid`, `rx_ready` and `rx_sync` are 0, and `err_count` is 0.
- R2: The select encoding is 00 = 7th-order sequence, 01 = 15th-order sequence, 10 = count, 11 = fixed word. Count mode emits 0, 1, 2, … on successive accepted words. Fixed mode emits 40'hF0F0F0F0F0 on every word.
- R3: Both sequences come from a shift register. Each step computes a new bit: for order 7 it is bit6 XOR bit5 (x^7+x^6+1), and for order 15 it is bit14 XOR bit13 (x^15+x^14+1). The register shifts left, and the new bit enters at bit 0 and is also the output bit. The register starts at all ones. Each word holds the next 40 output bits, the earliest in bit 39.
- R4: The generator advances by one word only on a cycle in which `tx_valid` and `tx_ready` are both high. While it is stalled, bits 39..1 of `tx_data` hold.
- R5: When `pat_sel` differs from the value in use, `tx_valid` is low until the next clock edge. At that edge the generator restarts from its seed, or from 0 in count mode.
- R6: A rising edge of `inject` inverts bit 0 of exactly one accepted word. That word is the first one accepted after the edge has been registered, even if the edge arrives during a stall. The sequence itself is not disturbed.
- R7: In either sequence mode, `rx_sync` rises once 4 consecutive received words match the word predicted from the bits received before them. In count and fixed modes `rx_sync` stays 0.
- R8: While `rx_sync` is high, each received word adds its number of mismatching bits to `err_count`. While `rx_sync` is low, `err_count` does not grow.
- R9: After 4 consecutive received words that contain errors, `rx_sync` falls. Three errored words in a row leave it high.
- R10: `err_count` saturates at all ones and stays there.
- R11: A change of `pat_sel` clears `err_count` and `rx_sync` at the next edge. In count and fixed modes the error total holds its value.
- R12: `rx_ready` is high whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_sel | input | 2 | Pattern select shared by the generator and the checker |
| inject | input | 1 | A rising edge corrupts bit 0 of one outgoing word |
| tx_data | output | 40 | Outgoing test word |
| tx_valid | output | 1 | Outgoing word is valid |
| tx_ready | input | 1 | Downstream accepts the outgoing word |
| rx_data | input | 40 | Received word |
| rx_valid | input | 1 | Received word is valid |
| rx_ready | output | 1 | Receive side can accept a word (no back-pressure) |
| rx_sync | output | 1 | Checker is locked to the received sequence |
| err_count | output | ERR_W | Saturating total of mismatching bits |

## Verification
Two generator events can fall in the same cycle: the inject edge and a stall on the outgoing stream. The bench raises `inject` while `tx_ready` is held low for several cycles and then resumes the stream. The scoreboard requires the inverted bit 0 on the first accepted word only, with the sequence unchanged around it. On the receive side, the fourth consecutive errored word must both be counted and drop sync. The bench provokes this with single-bit lane corruption and judges it from the exact `err_count` before and after the drop. Error saturation is provoked through a narrow counter and a burst of heavily corrupted words.

// File: rtl/ptg_pkg.sv
`timescale 1ns/1ps
package ptg_pkg;
  localparam int unsigned WORD_W = 40;
  localparam int unsigned LFSR_W = 15;
  localparam logic [WORD_W-1:0] FIXED_WORD = 40'hF0F0F0F0F0;

  typedef enum logic [1:0] {
    PAT_PRBS7  = 2'b00,
    PAT_PRBS15 = 2'b01,
    PAT_COUNT  = 2'b10,
    PAT_FIXED  = 2'b11
  } pat_e;

  // Next WORD_W sequence bits from state s, earliest bit in the MSB.
  function automatic logic [WORD_W-1:0] prbs_word(input logic [LFSR_W-1:0] s,
                                                  input logic long_mode);
    logic [LFSR_W-1:0] st;
    logic fb;
    logic [WORD_W-1:0] w;
    st = s;
    w  = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      fb = long_mode ? (st[14] ^ st[13]) : (st[6] ^ st[5]);
      st = {st[LFSR_W-2:0], fb};
      w[WORD_W-1-i] = fb;
    end
    return w;
  endfunction

  // Register contents after a word: its newest bits, masked to the order.
  function automatic logic [LFSR_W-1:0] prbs_state(input logic [WORD_W-1:0] w,
                                                   input logic long_mode);
    return long_mode ? w[LFSR_W-1:0] : {{(LFSR_W-7){1'b0}}, w[6:0]};
  endfunction
endpackage

// File: rtl/ptg_gen.sv
`timescale 1ns/1ps
module ptg_gen import ptg_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              inject,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid
);
  logic [1:0]        sel_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [WORD_W-1:0] cnt_q;
  logic              run_q;
  logic              inj_q;
  logic              pend_q;
  logic [WORD_W-1:0] raw_w;
  logic              change;
  logic              hs;
  logic              long_mode;

  assign long_mode = (sel_q == PAT_PRBS15);
  assign change    = (sel != sel_q);

  always_comb begin
    case (sel_q)
      PAT_PRBS7,
      PAT_PRBS15: raw_w = prbs_word(lfsr_q, long_mode);
      PAT_COUNT:  raw_w = cnt_q;
      default:    raw_w = FIXED_WORD;
    endcase
  end

  assign tx_valid = run_q & ~change;
  assign tx_data  = raw_w ^ {{(WORD_W-1){1'b0}}, pend_q};
  assign hs       = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= PAT_PRBS7;
      lfsr_q <= SEED;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      inj_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      inj_q  <= inject;
      pend_q <= (pend_q & ~hs) | (inject & ~inj_q);
      if (change) begin
        sel_q  <= sel;
        lfsr_q <= SEED;
        cnt_q  <= '0;
      end else if (hs) begin
        lfsr_q <= prbs_state(raw_w, long_mode);
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptg_chk.sv
`timescale 1ns/1ps
module ptg_chk import ptg_pkg::*; #(
  parameter int unsigned ERR_W  = 16,
  parameter int unsigned SYNC_N = 4,
  parameter int unsigned LOSS_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_sync,
  output logic [ERR_W-1:0]  err_count
);
  localparam int unsigned NB = $clog2(WORD_W + 1);
  localparam int unsigned CW = $clog2((SYNC_N > LOSS_N ? SYNC_N : LOSS_N) + 1);

  logic [1:0]        sel_q;
  logic [LFSR_W-1:0] ref_q;
  logic              lock_q;
  logic [CW-1:0]     good_q;
  logic [CW-1:0]     bad_q;
  logic [ERR_W-1:0]  err_q;
  logic              long_mode;
  logic              prbs_mode;
  logic [WORD_W-1:0] exp_w;
  logic [NB-1:0]     nerr;
  logic [ERR_W:0]    sum;
  logic [ERR_W-1:0]  err_sat;

  assign long_mode = (sel_q == PAT_PRBS15);
  assign prbs_mode = ~sel_q[1];
  assign exp_w     = prbs_word(ref_q, long_mode);
  assign nerr      = NB'($countones(exp_w ^ rx_data));
  assign sum       = {1'b0, err_q} + (ERR_W+1)'(nerr);
  assign err_sat   = sum[ERR_W] ? '1 : sum[ERR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= PAT_PRBS7;
      ref_q  <= '0;
      lock_q <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
      err_q  <= '0;
    end else if (sel != sel_q) begin
      sel_q  <= sel;
      ref_q  <= '0;
      lock_q <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
      err_q  <= '0;
    end else if (!prbs_mode) begin
      lock_q <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else if (rx_valid) begin
      if (!lock_q) begin
        ref_q <= prbs_state(rx_data, long_mode);
        if (nerr == '0) begin
          if (good_q == CW'(SYNC_N - 1)) begin
            lock_q <= 1'b1;
            good_q <= '0;
            bad_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end else begin
          good_q <= '0;
        end
      end else begin
        ref_q <= prbs_state(exp_w, long_mode);
        err_q <= err_sat;
        if (nerr != '0) begin
          if (bad_q == CW'(LOSS_N - 1)) begin
            lock_q <= 1'b0;
            bad_q  <= '0;
            good_q <= '0;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end else begin
          bad_q <= '0;
        end
      end
    end
  end

  assign rx_sync   = lock_q;
  assign err_count = err_q;
endmodule

// File: rtl/ptg_top.sv
`timescale 1ns/1ps
module ptg_top import ptg_pkg::*; #(
  parameter int unsigned       ERR_W  = 16,
  parameter int unsigned       SYNC_N = 4,
  parameter int unsigned       LOSS_N = 4,
  parameter logic [LFSR_W-1:0] SEED   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pat_sel,
  input  logic              inject,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              rx_sync,
  output logic [ERR_W-1:0]  err_count
);
  logic rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign rx_ready = rdy_q & rst_n;

  ptg_gen #(.SEED(SEED)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (pat_sel),
    .inject   (inject),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid)
  );

  ptg_chk #(.ERR_W(ERR_W), .SYNC_N(SYNC_N), .LOSS_N(LOSS_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (pat_sel),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid & rx_ready),
    .rx_sync   (rx_sync),
    .err_count (err_count)
  );
endmodule

// File: rtl/ptg_top_sva.sv
`timescale 1ns/1ps
module ptg_top_sva import ptg_pkg::*; #(
  parameter int unsigned ERR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pat_sel,
  input logic [WORD_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_sync,
  input logic [ERR_W-1:0]  err_count
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || tx_data[WORD_W-1:1] == $past(tx_data[WORD_W-1:1])));

  // R5
  sel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel != $past(pat_sel)) |-> !tx_valid);

  // R7
  sync_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync |-> ($past(pat_sel) == 2'b00 || $past(pat_sel) == 2'b01));

  // R8
  grow_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count > $past(err_count)) |-> $past(rx_sync));

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_count) == '1 && pat_sel == $past(pat_sel) && $past(pat_sel) == $past(pat_sel, 2))
      |-> err_count == '1);

  // R11
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == $past(pat_sel) && $past(pat_sel) == $past(pat_sel, 2))
      |-> err_count >= $past(err_count));
endmodule

bind ptg_top ptg_top_sva #(.ERR_W(ERR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .pat_sel   (pat_sel),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_sync   (rx_sync),
  .err_count (err_count)
);

// File: tb/tb_ptg_top.sv
`timescale 1ns/1ps
module tb_ptg_top;
  localparam int ERR_W = 6;
  localparam int LANE  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pat_sel;
  logic        inject;
  logic [39:0] tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [39:0] rx_data;
  logic        rx_valid;
  logic        rx_ready;
  logic        rx_sync;
  logic [ERR_W-1:0] err_count;
  logic [39:0] cmask;

  int n_chk = 0;
  int n_err = 0;

  logic [39:0] exp_q[$];
  int          tag_q[$];
  logic        flip_req = 1'b0;
  logic        armed    = 1'b0;

  logic [14:0] m_lfsr;
  logic [39:0] m_cnt;
  int          m_mode;

  logic [39:0] ln_d[LANE];
  logic        ln_v[LANE];

  always #4 clk = ~clk;

  ptg_top #(.ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .inject(inject),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sync(rx_sync), .err_count(err_count)
  );

  // Lane: LANE register stages with optional corruption on entry.
  always @(posedge clk) begin
    ln_v[0] <= tx_valid && tx_ready;
    ln_d[0] <= tx_data ^ cmask;
    for (int k = 1; k < LANE; k++) begin
      ln_v[k] <= ln_v[k-1];
      ln_d[k] <= ln_d[k-1];
    end
  end
  assign rx_valid = ln_v[LANE-1];
  assign rx_data  = ln_d[LANE-1];

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic next_expected(output logic [39:0] w);
    logic fb;
    w = '0;
    case (m_mode)
      0, 1: for (int i = 0; i < 40; i++) begin
              fb = (m_mode == 1) ? (m_lfsr[14] ^ m_lfsr[13]) : (m_lfsr[6] ^ m_lfsr[5]);
              m_lfsr = {m_lfsr[13:0], fb};
              w[39-i] = fb;
            end
      2: begin w = m_cnt; m_cnt = m_cnt + 1; end
      default: w = 40'hF0F0F0F0F0;
    endcase
  endtask

  // Driver: push expected words, then grant one handshake per word.
  task automatic send(input int n, input int stall_every, input logic [39:0] mask, input int nmask);
    logic [39:0] w;
    for (int i = 0; i < n; i++) begin
      if (stall_every > 0 && i > 0 && (i % stall_every) == 0) begin
        tx_ready = 1'b0; cmask = '0;
        @(posedge clk); #2;
      end
      next_expected(w);
      exp_q.push_back(w);
      tag_q.push_back(m_mode);
      tx_ready = 1'b1;
      cmask = (i < nmask) ? mask : '0;
      @(posedge clk); #2;
    end
    tx_ready = 1'b0; cmask = '0;
  endtask

  task automatic settle();
    repeat (LANE + 3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic resume();
    @(posedge clk); #2;
  endtask

  task automatic set_mode(input int m);
    pat_sel = 2'(m);
    @(negedge clk);
    check(tx_valid == 1'b0, "R5 valid gap", tx_valid, 0);
    @(posedge clk); #2;
    m_mode = m; m_lfsr = 15'h7FFF; m_cnt = '0;
    @(negedge clk);
    check(tx_valid == 1'b1, "R5 valid back", tx_valid, 1);
    check(rx_sync == 1'b0, "R11 sync cleared", rx_sync, 0);
    check(err_count == '0, "R11 count cleared", err_count, 0);
    resume();
  endtask

  // Monitor: compare each accepted word with the scoreboard head.
  initial begin
    logic [39:0] e;
    int t;
    string tg;
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", tx_data, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          tg = (t < 2) ? "R3 sequence word" : "R2 pattern word";
          if (armed) begin
            e[0] = ~e[0];
            armed = 1'b0;
            tg = "R6 injected word";
          end
          check(tx_data == e, tg, tx_data, e);
        end
      end
      if (flip_req) begin
        armed = 1'b1;
        flip_req = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [39:0] a;
    rst_n = 1'b0; pat_sel = 2'b00; inject = 1'b0; tx_ready = 1'b0; cmask = '0;
    m_mode = 0; m_lfsr = 15'h7FFF; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_valid == 1'b0, "R1 tx_valid in reset", tx_valid, 0);
    check(rx_ready == 1'b0, "R1 rx_ready in reset", rx_ready, 0);
    check(rx_sync == 1'b0, "R1 sync in reset", rx_sync, 0);
    check(err_count == '0, "R1 count in reset", err_count, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    resume();
    @(negedge clk);
    check(rx_ready == 1'b1, "R12 rx_ready after reset", rx_ready, 1);
    resume();

    // 7th-order sequence with stalls, then lock
    send(12, 3, '0, 0);
    @(negedge clk); a = tx_data;
    @(negedge clk);
    check(tx_data == a, "R4 word held in stall", tx_data, a);
    settle();
    check(rx_sync == 1'b1, "R7 locked on order 7", rx_sync, 1);
    check(err_count == '0, "R8 clean link", err_count, 0);
    resume();

    // injection on a flowing stream
    inject = 1'b1; flip_req = 1'b1;
    send(3, 0, '0, 0);
    inject = 1'b0;
    settle();
    check(err_count == 6'd1, "R6 one injected bit", err_count, 1);
    resume();

    // three corrupted bits on one word
    send(6, 0, 40'h80_0010_0400, 1);
    settle();
    check(err_count == 6'd4, "R8 bit count added", err_count, 4);
    check(rx_sync == 1'b1, "R9 one bad word keeps lock", rx_sync, 1);
    resume();

    // injection edge during a stall
    inject = 1'b1; flip_req = 1'b1;
    repeat (3) begin @(posedge clk); #2; end
    send(4, 0, '0, 0);
    inject = 1'b0;
    settle();
    check(err_count == 6'd5, "R6 stall injection counted once", err_count, 5);
    resume();

    // 15th-order sequence: exact lock point
    set_mode(1);
    send(4, 0, '0, 0);
    settle();
    check(rx_sync == 1'b0, "R7 not locked after 4 words", rx_sync, 0);
    resume();
    send(1, 0, '0, 0);
    settle();
    check(rx_sync == 1'b1, "R7 locked after 5th word", rx_sync, 1);
    resume();

    // loss of lock
    send(3, 0, 40'h80_0000_0000, 3);
    settle();
    check(rx_sync == 1'b1, "R9 three bad words keep lock", rx_sync, 1);
    check(err_count == 6'd3, "R8 three errors", err_count, 3);
    resume();
    send(1, 0, 40'h80_0000_0000, 1);
    settle();
    check(rx_sync == 1'b0, "R9 fourth bad word drops lock", rx_sync, 0);
    check(err_count == 6'd4, "R9 fourth bad word counted", err_count, 4);
    resume();
    send(6, 2, '0, 0);
    settle();
    check(rx_sync == 1'b1, "R7 relocked", rx_sync, 1);
    check(err_count == 6'd4, "R8 no growth while unlocked", err_count, 4);
    resume();

    // saturation
    send(3, 0, 40'h00_3FFF_FFFF, 3);
    settle();
    check(err_count == 6'h3F, "R10 saturated", err_count, 63);
    resume();
    send(2, 0, '0, 0);
    settle();
    check(err_count == 6'h3F, "R10 stays saturated", err_count, 63);
    resume();

    // count and fixed modes
    set_mode(2);
    send(5, 2, '0, 0);
    settle();
    check(rx_sync == 1'b0, "R11 no lock in count mode", rx_sync, 0);
    check(err_count == '0, "R11 count held in count mode", err_count, 0);
    resume();
    set_mode(3);
    send(3, 0, '0, 0);
    settle();
    check(rx_sync == 1'b0, "R11 no lock in fixed mode", rx_sync, 0);
    check(exp_q.size() == 0, "R4 every word delivered", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule